// File: doc/BRIEF.md
# Numerically Controlled Frequency Generator

This block derives a slower periodic signal from a fixed reference clock. A 16-bit control word is folded into an effective step, and the step is added to a 16-bit phase accumulator on every reference cycle while the channel runs. The accumulator's top bit is the square-wave output. A one-cycle tick marks each rising edge of that square wave and clocks a downstream pulse-width stage. The output frequency is the step times 2^-16 times the reference frequency. A control word at or above half scale uses its 16-bit two's complement as the step, so the output frequency folds symmetrically about half the reference.

Software loads the control word as two bytes. A high-byte write only stages the byte. A low-byte write commits the staged high byte and the new low byte together, so the accumulator never adds a half-updated step. A start input runs the channel. While start is low, the accumulator is held cleared.

Top module: `nco_freq_gen`

## Requirements
- R1: After reset, `sq_out` and `tick` are low and the committed control word is 0, so asserting `start` with no word written leaves both outputs low.
- R2: The step W equals the word when the word is below 0x8000. Otherwise W equals (0x10000 - word) mod 0x10000. Words 0xC000 and 0x4000 therefore produce the same output.
- R3: While `start` is high, the accumulator adds W on each clock edge. After the k-th edge with `start` high, counting from a cleared accumulator, `sq_out` equals bit 15 of (k*W mod 0x10000).
- R4: `tick` is high for exactly one cycle, in the cycle where `sq_out` goes from 0 to 1, and is low at all other times.
- R5: A power-of-two step gives a square wave with exactly 50% duty. For example, 0x4000 gives 2 cycles high and 2 cycles low.
- R6: A word of 0 freezes the accumulator and holds `sq_out` low. This holds even when the word becomes 0 while `sq_out` is high.
- R7: When `start` is low at a clock edge, the accumulator clears, and `sq_out` and `tick` are low from that edge on. A restart begins again from phase zero.
- R8: A write with `wr_hi` high and `wr_lo` low only stages `wr_data` as the pending high byte (bits 15:8). The step in use does not change.
- R9: A write with `wr_lo` high commits {pending high byte, `wr_data`} as the control word (low byte in bits 7:0). The new word is used from the next clock edge on.
- R10: When `wr_hi` and `wr_lo` are both high in one cycle, `wr_data` supplies both bytes of the committed word.
- R11: Word 0x8000 gives the maximum step of 0x8000. `sq_out` toggles every cycle (half the reference) and `tick` fires every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run the channel; low holds the accumulator cleared |
| wr_hi | input | 1 | Stage `wr_data` as the pending high byte |
| wr_lo | input | 1 | Commit pending high byte with `wr_data` as the low byte |
| wr_data | input | 8 | Byte written by either strobe |
| sq_out | output | 1 | Square wave, the accumulator top bit gated by a nonzero word |
| tick | output | 1 | One-cycle pulse on each rising edge of `sq_out` |

## Verification
Two pairs of functions can fall in the same cycle. First, a word commit can coincide with a live accumulator step: the bench drives the word to zero while `sq_out` is high with `start` held, and expects the output low from the commit edge onward. Second, the high-byte staging and the low-byte commit can coincide: both strobes are raised together with one data byte, and the whole resulting waveform is compared sample by sample against an accumulator model built from the folding rule.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int MSB    = WORD_W - 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    // Byte-write staging state
    typedef struct packed {
        byte_t hi_pend;
        word_t word;
    } wr_state_t;

    // Phase accumulator state
    typedef struct packed {
        word_t acc;
        logic  sq_d;
    } acc_state_t;

    // Words at or above half scale step by their two's complement
    function automatic word_t fold_step(word_t w);
        word_t r;
        if (w[MSB]) r = word_t'(~w) + word_t'(1);
        else        r = w;
        return r;
    endfunction

endpackage

// File: rtl/nco_word_stage.sv
module nco_word_stage
    import nco_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_hi,
    input  logic  wr_lo,
    input  byte_t wr_data,
    output word_t word_o
);

    wr_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_hi) st_d.hi_pend = wr_data;
        if (wr_lo) st_d.word = {st_d.hi_pend, wr_data};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word_o = st_q.word;

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
    import nco_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  active,
    input  word_t step,
    output logic  sq,
    output logic  edge_pulse
);

    acc_state_t st_q, st_d;
    logic       sq_now;

    assign sq_now = st_q.acc[MSB] & active;

    always_comb begin
        st_d      = st_q;
        st_d.sq_d = sq_now;
        if (!run) st_d.acc = '0;
        else      st_d.acc = st_q.acc + step;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sq         = sq_now;
    assign edge_pulse = sq_now & ~st_q.sq_d;

endmodule

// File: rtl/nco_freq_gen.sv
module nco_freq_gen
    import nco_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              sq_out,
    output logic              tick
);

    word_t word_q;
    word_t step_w;
    logic  word_nz;

    nco_word_stage u_stage (
        .clk    (clk),
        .rst    (rst),
        .wr_hi  (wr_hi),
        .wr_lo  (wr_lo),
        .wr_data(wr_data),
        .word_o (word_q)
    );

    assign step_w  = fold_step(word_q);
    assign word_nz = |word_q;

    nco_phase_acc u_acc (
        .clk       (clk),
        .rst       (rst),
        .run       (start),
        .active    (word_nz),
        .step      (step_w),
        .sq        (sq_out),
        .edge_pulse(tick)
    );

endmodule

// File: rtl/nco_freq_gen_chk.sv
module nco_freq_gen_chk
    import nco_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  start,
    input logic  wr_hi,
    input logic  wr_lo,
    input byte_t wr_data,
    input word_t word,
    input logic  sq_out,
    input logic  tick
);

    p_tick_on_high_r4: assert property (@(posedge clk) disable iff (rst)
        tick |-> sq_out);

    p_tick_single_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    p_zero_word_low_r6: assert property (@(posedge clk) disable iff (rst)
        (word == '0) |-> !sq_out);

    p_stop_clears_r7: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!sq_out && !tick));

    p_hi_stage_only_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && !wr_lo) |=> $stable(word));

    p_lo_commits_r9: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (word[BYTE_W-1:0] == $past(wr_data)));

    p_half_toggle_r11: assert property (@(posedge clk) disable iff (rst)
        (start && $past(start) && word == 16'h8000 && $past(word) == 16'h8000)
        |-> (sq_out != $past(sq_out)));

endmodule

bind nco_freq_gen nco_freq_gen_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .wr_hi  (wr_hi),
    .wr_lo  (wr_lo),
    .wr_data(wr_data),
    .word   (word_q),
    .sq_out (sq_out),
    .tick   (tick)
);

// File: tb/sim_nco_freq_gen.sv
module sim_nco_freq_gen;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic       wr_hi;
    logic       wr_lo;
    logic [7:0] wr_data;
    logic       sq_out;
    logic       tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    nco_freq_gen u0 (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .wr_hi  (wr_hi),
        .wr_lo  (wr_lo),
        .wr_data(wr_data),
        .sq_out (sq_out),
        .tick   (tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int fold(input int w);
        return (w < 32768) ? w : (65536 - w) % 65536;
    endfunction

    task automatic write_hi(input logic [7:0] d);
        wr_hi = 1'b1; wr_data = d;
        @(negedge clk);
        wr_hi = 1'b0;
    endtask

    task automatic write_lo(input logic [7:0] d);
        wr_lo = 1'b1; wr_data = d;
        @(negedge clk);
        wr_lo = 1'b0;
    endtask

    task automatic load_word(input int w);
        write_hi(8'(w >> 8));
        write_lo(8'(w & 255));
    endtask

    // Runs from a cleared accumulator for n cycles, compares to the R3/R4 model
    task automatic run_model(input int w_step, input int n,
                             output int mism, output int highs, output int ticks);
        bit prev = 0;
        mism = 0; highs = 0; ticks = 0;
        start = 1'b1;
        for (int k = 1; k <= n; k++) begin
            int  a;
            bit  es, et;
            @(negedge clk);
            a  = (k * w_step) % 65536;
            es = (w_step != 0) && (a >= 32768);
            et = es && !prev;
            prev = es;
            if (sq_out !== es || tick !== et) mism++;
            if (sq_out === 1'b1) highs++;
            if (tick === 1'b1) ticks++;
        end
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        int m, h, t;
        check(sq_out === 1'b0, "R1 sq_out after reset", sq_out, 0);
        check(tick === 1'b0, "R1 tick after reset", tick, 0);
        run_model(0, 8, m, h, t);
        check(h == 0 && t == 0, "R1 no output with default word", h + t, 0);
    endtask

    task automatic t_pow2;
        int m, h, t;
        load_word(16'h4000);
        run_model(fold(16'h4000), 16, m, h, t);
        check(m == 0, "R3 waveform 0x4000", m, 0);
        check(h == 8, "R5 duty highs 0x4000", h, 8);
        check(t == 4, "R4 ticks 0x4000", t, 4);
        load_word(16'h0800);
        run_model(fold(16'h0800), 64, m, h, t);
        check(h == 32, "R5 duty highs 0x0800", h, 32);
    endtask

    task automatic t_fold;
        int m, h, t;
        load_word(16'hC000);
        run_model(fold(16'h4000), 16, m, h, t);
        check(m == 0, "R2 0xC000 folds to 0x4000", m, 0);
        load_word(16'hF000);
        run_model(fold(16'hF000), 64, m, h, t);
        check(t == 4, "R2 ticks 0xF000", t, 4);
        load_word(16'h0123);
        run_model(fold(16'h0123), 300, m, h, t);
        check(m == 0, "R3 waveform 0x0123", m, 0);
        load_word(16'hFEDD);
        run_model(fold(16'hFEDD), 300, m, h, t);
        check(m == 0, "R2 waveform 0xFEDD", m, 0);
    endtask

    task automatic t_half;
        int m, h, t;
        load_word(16'h8000);
        run_model(32768, 16, m, h, t);
        check(m == 0, "R11 toggle every cycle", m, 0);
        check(t == 8, "R11 ticks at half rate", t, 8);
    endtask

    task automatic t_stage;
        int m, h, t;
        load_word(16'h4000);
        write_hi(8'h80);
        run_model(fold(16'h4000), 16, m, h, t);
        check(m == 0 && t == 4, "R8 staged high byte unused", t, 4);
        write_lo(8'h00);
        run_model(fold(16'h8000), 16, m, h, t);
        check(m == 0 && t == 8, "R9 commit after low byte", t, 8);
    endtask

    task automatic t_stop;
        int m, h, t;
        load_word(16'h4000);
        start = 1'b1;
        repeat (3) @(negedge clk);
        check(sq_out === 1'b1, "R7 running high before stop", sq_out, 1);
        start = 1'b0;
        @(negedge clk);
        check(sq_out === 1'b0 && tick === 1'b0, "R7 stop clears output", sq_out, 0);
        run_model(fold(16'h4000), 16, m, h, t);
        check(m == 0, "R7 restart from phase zero", m, 0);
    endtask

    task automatic t_zero_mid;
        load_word(16'h1000);
        start = 1'b1;
        repeat (8) @(negedge clk);
        check(sq_out === 1'b1, "R6 high before zero word", sq_out, 1);
        write_hi(8'h00);
        write_lo(8'h00);
        check(sq_out === 1'b0, "R6 zero word forces low", sq_out, 0);
        repeat (20) @(negedge clk);
        check(sq_out === 1'b0 && tick === 1'b0, "R6 held low while frozen", sq_out, 0);
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_both;
        int m, h, t;
        wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 8'h80;
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b0;
        run_model(fold(16'h8080), 64, m, h, t);
        check(m == 0, "R10 both strobes give 0x8080", m, 0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_pow2;
        t_fold;
        t_half;
        t_stage;
        t_stop;
        t_zero_mid;
        t_both;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule